// File: doc/BRIEF.md
# Cache Line Coherency State Controller

This block keeps the four-state coherency status (Modified, Exclusive, Shared, Invalid) of every line in a small L1 data cache. Each line holds 32 bytes. Cache-management operations arrive one per cycle. Each operation carries a line index, an operation code, a cache-target flag, the three W/I/M page attributes and the bus shared response. The block finds the line's stored status, works out the status that follows, and writes it back into its state table.

Every operation is answered one cycle later on registered outputs. These show the status before the operation and the status after it. One of two pulses comes with them: accepted if the operation was applied, not-applicable if its attribute condition failed or the code is unknown. A separate read port returns the registered status of any line. Tag matching, the data array, bus traffic, write-back data and lock bits are kept outside this block.

Top module: `ccs_ctrl`

## Requirements
- R1: Reset (synchronous, active high) sets every line to the code 000. It also clears `cur_state`, `nxt_state`, `rd_state`, `op_accept` and `op_na` to zero.
- R2: Status codes are M=101, E=100, S=110 and I=000. Any code with bit 2 clear reads as Invalid, and the table only ever stores these four codes.
- R3: Flush (code 0), invalidate (code 1) and store (code 2) set the line to I from any status, whatever the attributes are. Attributes are ordered `op_wim[2]`=W, `op_wim[1]`=I, `op_wim[0]`=M.
- R4: Allocate-zero (code 3) with W=0 and I=0 sets the line to M from any status. M is a don't-care.
- R5: Lock-clear (code 8) is always accepted and leaves the status unchanged, for either value of the cache-target flag.
- R6: Touch (code 4) and touch-and-lock (code 5) with target 0 and I=0 keep M, E and S unchanged. An I line becomes S when `snoop_shared` is 1 and E when it is 0.
- R7: Touch-for-store (code 6) with target 0 and W=I=0 turns I into E and keeps M, E and S unchanged.
- R8: Touch-for-store-and-lock (code 7) with target 0 and W=I=0 keeps M and E unchanged and turns S or I into E.
- R9: Touch-type operations (codes 4 to 7) with target 1 whose attribute condition holds set the line to I.
- R10: If the attribute condition of an operation fails, or the code is 9 to 15, the status is left unchanged. `op_na` pulses for one cycle and `op_accept` stays low.
- R11: `op_accept`/`op_na`, `cur_state` and `nxt_state` appear on the cycle after `op_valid`. `cur_state` and `nxt_state` hold when no operation arrives, and a back-to-back operation on the same line sees the state just written.
- R12: `rd_state` is registered and shows the status at the clock edge where `rd_index` is sampled. If the same line is updated at that edge, the value from before the update is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_index | input | IDX_W | Line addressed by the operation |
| op_code | input | 4 | Operation code |
| op_target | input | 1 | Cache-target flag (1 = operation aimed beyond L1) |
| op_wim | input | 3 | Attributes W, I, M (bits 2, 1, 0) |
| snoop_shared | input | 1 | Bus shared response for fills from Invalid |
| rd_index | input | IDX_W | Line to read back |
| rd_state | output | 3 | Registered status of the line at `rd_index` |
| cur_state | output | 3 | Status before the last operation |
| nxt_state | output | 3 | Status after the last operation |
| op_accept | output | 1 | Last operation was applied |
| op_na | output | 1 | Last operation was not applicable |

## Verification
A status read and a status update can hit the same line in the same cycle. The bench provokes this by pointing `rd_index` at `op_index` in a directed case and in about half of the random cycles. The reference model records the line's value before it applies the operation, and the read port is judged against that old value. Back-to-back operations on one line are also driven, so that a lookup right after a write is compared against the updated model.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int OPC_W = 4;
  localparam int ST_W  = 3;

  localparam logic [ST_W-1:0] ST_I = 3'b000;
  localparam logic [ST_W-1:0] ST_E = 3'b100;
  localparam logic [ST_W-1:0] ST_S = 3'b110;
  localparam logic [ST_W-1:0] ST_M = 3'b101;

  localparam logic [OPC_W-1:0] OP_FLUSH   = 4'd0;
  localparam logic [OPC_W-1:0] OP_INVAL   = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE   = 4'd2;
  localparam logic [OPC_W-1:0] OP_ZALLOC  = 4'd3;
  localparam logic [OPC_W-1:0] OP_TOUCH   = 4'd4;
  localparam logic [OPC_W-1:0] OP_TOUCHLK = 4'd5;
  localparam logic [OPC_W-1:0] OP_TST     = 4'd6;
  localparam logic [OPC_W-1:0] OP_TSTLK   = 4'd7;
  localparam logic [OPC_W-1:0] OP_LCLR    = 4'd8;

  // W, I, M attribute positions inside the 3-bit attribute field
  localparam int WIM_W = 2;
  localparam int WIM_I = 1;
endpackage

// File: rtl/ccs_next_state.sv
module ccs_next_state
  import ccs_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  input  logic             target,
  input  logic [2:0]       wim,
  input  logic             shared,
  input  logic [ST_W-1:0]  cur,
  output logic [ST_W-1:0]  nxt,
  output logic             not_app
);
  logic inh_ok;     // I = 0
  logic wt_inh_ok;  // W = 0 and I = 0
  logic cur_valid;

  assign inh_ok    = ~wim[WIM_I];
  assign wt_inh_ok = ~wim[WIM_W] & ~wim[WIM_I];
  assign cur_valid = cur[ST_W-1];

  always_comb begin
    nxt     = cur;
    not_app = 1'b0;
    case (op)
      OP_FLUSH, OP_INVAL, OP_STORE: nxt = ST_I;
      OP_ZALLOC: begin
        if (wt_inh_ok) nxt = ST_M;
        else           not_app = 1'b1;
      end
      OP_LCLR: nxt = cur;
      OP_TOUCH, OP_TOUCHLK: begin
        if (!inh_ok)         not_app = 1'b1;
        else if (target)     nxt = ST_I;
        else if (!cur_valid) nxt = shared ? ST_S : ST_E;
      end
      OP_TST: begin
        if (!wt_inh_ok)      not_app = 1'b1;
        else if (target)     nxt = ST_I;
        else if (!cur_valid) nxt = ST_E;
      end
      OP_TSTLK: begin
        if (!wt_inh_ok)                     not_app = 1'b1;
        else if (target)                    nxt = ST_I;
        else if (!cur_valid || cur == ST_S) nxt = ST_E;
      end
      default: not_app = 1'b1;
    endcase
  end
endmodule

// File: rtl/ccs_state_array.sv
module ccs_state_array
  import ccs_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ST_W-1:0]  wr_state,
  input  logic [IDX_W-1:0] look_idx,
  output logic [ST_W-1:0]  look_state,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ST_W-1:0]  rd_state
);
  logic [LINES-1:0][ST_W-1:0] lines_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [ST_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= ST_I;
      else if (wr_en && wr_idx == IDX_W'(g))     q <= wr_state;
    end
    assign lines_q[g] = q;
  end

  assign look_state = lines_q[look_idx];

  always_ff @(posedge clk) begin
    if (rst) rd_state <= ST_I;
    else     rd_state <= lines_q[rd_idx];
  end
endmodule

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [IDX_W-1:0] op_index,
  input  logic [3:0]       op_code,
  input  logic             op_target,
  input  logic [2:0]       op_wim,
  input  logic             snoop_shared,
  input  logic [IDX_W-1:0] rd_index,
  output logic [2:0]       rd_state,
  output logic [2:0]       cur_state,
  output logic [2:0]       nxt_state,
  output logic             op_accept,
  output logic             op_na
);
  logic [ST_W-1:0] look_state;
  logic [ST_W-1:0] calc_state;
  logic            calc_na;
  logic            wr_en;

  ccs_state_array #(.LINES(LINES), .IDX_W(IDX_W)) u_arr (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (op_index),
    .wr_state   (calc_state),
    .look_idx   (op_index),
    .look_state (look_state),
    .rd_idx     (rd_index),
    .rd_state   (rd_state)
  );

  ccs_next_state u_ns (
    .op      (op_code),
    .target  (op_target),
    .wim     (op_wim),
    .shared  (snoop_shared),
    .cur     (look_state),
    .nxt     (calc_state),
    .not_app (calc_na)
  );

  assign wr_en = op_valid & ~calc_na;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_state <= ST_I;
      nxt_state <= ST_I;
      op_accept <= 1'b0;
      op_na     <= 1'b0;
    end else begin
      op_accept <= op_valid & ~calc_na;
      op_na     <= op_valid &  calc_na;
      if (op_valid) begin
        cur_state <= look_state;
        nxt_state <= calc_na ? look_state : calc_state;
      end
    end
  end
endmodule

// File: rtl/ccs_ctrl_chk.sv
module ccs_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic       op_target,
  input logic [2:0] op_wim,
  input logic [2:0] cur_state,
  input logic [2:0] nxt_state,
  input logic       op_accept,
  input logic       op_na
);
  assert_one_reply_R11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (op_accept != op_na));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!op_accept && !op_na && $stable(cur_state) && $stable(nxt_state)));

  assert_kill_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 4'd2) |=> (op_accept && nxt_state == 3'b000));

  assert_zero_alloc_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd3 && op_wim[2:1] == 2'b00) |=> (op_accept && nxt_state == 3'b101));

  assert_lock_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd8) |=> (op_accept && nxt_state == cur_state));

  assert_far_touch_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_target && !op_wim[1] && (op_code == 4'd4 || op_code == 4'd5))
      |=> (nxt_state == 3'b000));

  assert_na_hold_R10: assert property (@(posedge clk) disable iff (rst)
    op_na |-> (nxt_state == cur_state));

  assert_unknown_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 4'd9) |=> op_na);
endmodule

bind ccs_ctrl ccs_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_target (op_target),
  .op_wim    (op_wim),
  .cur_state (cur_state),
  .nxt_state (nxt_state),
  .op_accept (op_accept),
  .op_na     (op_na)
);

// File: tb/sim_ccs_ctrl.sv
`timescale 1ns/1ps
module sim_ccs_ctrl;
  localparam int NL = 16;
  localparam int IW = 4;

  logic          clk = 0;
  logic          rst = 1;
  logic          op_valid = 0;
  logic [IW-1:0] op_index = '0;
  logic [3:0]    op_code = '0;
  logic          op_target = 0;
  logic [2:0]    op_wim = '0;
  logic          snoop_shared = 0;
  logic [IW-1:0] rd_index = '0;
  logic [2:0]    rd_state, cur_state, nxt_state;
  logic          op_accept, op_na;

  ccs_ctrl #(.LINES(NL), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_index(op_index),
    .op_code(op_code), .op_target(op_target), .op_wim(op_wim),
    .snoop_shared(snoop_shared), .rd_index(rd_index), .rd_state(rd_state),
    .cur_state(cur_state), .nxt_state(nxt_state), .op_accept(op_accept), .op_na(op_na)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [2:0] model [NL];
  logic [2:0] e_cur = 0, e_nxt = 0, e_rd = 0;
  bit         e_acc = 0, e_na = 0;
  string      e_tag = "R1";

  // Independent reference transition, written from the requirements
  function automatic void ref_step(input int op, input bit tgt, input bit w, input bit i,
                                   input bit sh, input logic [2:0] s,
                                   output logic [2:0] n, output bit na, output string tag);
    bit valid_line = (s[2] == 1'b1);
    n = s; na = 0;
    if (op == 0 || op == 1 || op == 2) begin n = 3'b000; tag = "R3"; end
    else if (op == 3) begin tag = "R4"; if (!w && !i) n = 3'b101; else na = 1; end
    else if (op == 8) begin tag = "R5"; end
    else if (op == 4 || op == 5) begin
      tag = tgt ? "R9" : "R6";
      if (i) begin na = 1; tag = "R10"; end
      else if (tgt) n = 3'b000;
      else if (!valid_line) n = sh ? 3'b110 : 3'b100;
    end else if (op == 6 || op == 7) begin
      tag = tgt ? "R9" : (op == 6 ? "R7" : "R8");
      if (w || i) begin na = 1; tag = "R10"; end
      else if (tgt) n = 3'b000;
      else if (!valid_line) n = 3'b100;
      else if (op == 7 && s == 3'b110) n = 3'b100;
    end else begin na = 1; tag = "R10"; end
  endfunction

  task automatic check_outputs();
    vectors++;
    if (cur_state !== e_cur || nxt_state !== e_nxt || op_accept !== e_acc ||
        op_na !== e_na || rd_state !== e_rd) begin
      miscompares++;
      $display("FAIL %s/R11/R12: cur=%b nxt=%b acc=%b na=%b rd=%b expected cur=%b nxt=%b acc=%b na=%b rd=%b",
               e_tag, cur_state, nxt_state, op_accept, op_na, rd_state,
               e_cur, e_nxt, e_acc, e_na, e_rd);
    end
  endtask

  task automatic step(input bit v, input int idx, input int op, input bit tgt,
                      input logic [2:0] wim, input bit sh, input int rdi);
    logic [2:0] n;
    bit na;
    string tag;
    @(negedge clk);
    check_outputs();
    e_rd = model[rdi];           // R12: read-first value
    if (v) begin
      ref_step(op, tgt, wim[2], wim[1], sh, model[idx], n, na, tag);
      e_cur = model[idx];
      e_nxt = n;
      e_acc = !na;
      e_na  = na;
      e_tag = tag;
      if (!na) model[idx] = n;
    end else begin
      e_acc = 0; e_na = 0; e_tag = "R11";
    end
    op_valid = v; op_index = IW'(idx); op_code = 4'(op); op_target = tgt;
    op_wim = wim; snoop_shared = sh; rd_index = IW'(rdi);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; op_valid = 0; rd_index = '0;
    foreach (model[k]) model[k] = 3'b000;
    e_cur = 0; e_nxt = 0; e_acc = 0; e_na = 0; e_rd = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    do_reset();
    step(0, 0, 0, 0, 3'b000, 0, 0);                 // R1 reset values
    step(1, 0, 4, 0, 3'b000, 1, 0);                 // R6 I -> S
    step(1, 1, 5, 0, 3'b001, 0, 1);                 // R6 I -> E
    step(1, 0, 4, 0, 3'b000, 0, 0);                 // R6 S stays
    step(1, 0, 7, 0, 3'b000, 0, 0);                 // R8 S -> E, back-to-back R11
    step(1, 2, 3, 0, 3'b001, 0, 2);                 // R4 -> M (R2 code 101)
    step(1, 2, 6, 0, 3'b000, 0, 2);                 // R7 M stays
    step(1, 3, 6, 0, 3'b000, 0, 3);                 // R7 I -> E
    step(1, 2, 4, 1, 3'b000, 0, 2);                 // R9 target 1 -> I
    step(1, 4, 4, 0, 3'b010, 0, 4);                 // R10 I=1 not applicable
    step(1, 4, 3, 0, 3'b100, 0, 4);                 // R10 W=1 zero-alloc
    step(1, 1, 8, 1, 3'b111, 0, 1);                 // R5 lock-clear, target 1
    step(1, 1, 2, 0, 3'b111, 0, 1);                 // R3 store -> I
    step(1, 3, 12, 0, 3'b000, 0, 3);                // R10 unknown code
    step(1, 0, 0, 0, 3'b101, 0, 0);                 // R3 flush, same-cycle read R12
    step(0, 0, 0, 0, 3'b000, 0, 0);                 // R11 outputs hold, R12 read new
    for (int k = 0; k < 4000; k++) begin
      int idx = $urandom_range(NL-1);
      int rdi = $urandom_range(1) ? idx : int'($urandom_range(NL-1));
      step($urandom_range(7) != 0, idx, $urandom_range(15), $urandom_range(1),
           3'($urandom_range(7)), $urandom_range(1), rdi);
    end
    do_reset();                                     // R1 mid-run reset
    for (int k = 0; k < NL; k++) step(0, 0, 0, 0, 3'b000, 0, k);
    step(0, 0, 0, 0, 3'b000, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule